// File: doc/BRIEF.md
# Footprint Next-Line Prefetch Predictor

This block decides which of the next few sequential cache lines to prefetch after a miss in a small shadow tag cache. Each miss arrives as a trigger carrying block address B. The block keeps two small direct-mapped tables indexed by the low bits of the block address. The first holds a one-bit "recently used" flag per entry. The second holds a two-bit saturating usefulness counter per entry.

A trigger does three things. It marks B as used. If the block just below B was used, it raises that block's counter to full strength, because a use of B followed it. It then walks forward from B and proposes B+1, B+2 and so on for as long as each preceding block's counter says it is worth following. Proposed block addresses enter a small output queue, which a downstream request arbiter drains through a valid/ready handshake.

A background sweep ages the tables after a fixed number of triggers. It also runs without any trigger. A filter input marks the case where the lower neighbour was already prefetched. In that case, and when the lower neighbour is itself marked used, the walk emits only its farthest candidate.

Top module: `fnl_prefetch_predictor`

## Requirements
- R1: After reset `miss_ready` is 1 and `pf_valid` is 0. Every usefulness counter and used flag is 0, so the first triggers on fresh blocks emit no candidates.
- R2: An accepted trigger on block B sets the used flag of table entry B mod 2^IDX_W.
- R3: If the used flag of entry (B-1) mod 2^IDX_W is set when a trigger on B is accepted, that entry's counter becomes 3.
- R4: Candidate B+k, for k from 1 to MAX_AHEAD (default 5), is emitted only when the counters of B, B+1, ..., B+k-1 are all at least 2. Candidates leave the block in ascending order of k.
- R5: The walk ends at the first block whose counter is below 2. No later candidate of that trigger is emitted.
- R6: No candidate is emitted outside the page of B. A page holds 2^PAGE_W blocks, and candidate C is in the page of B when C>>PAGE_W equals B>>PAGE_W. Addresses wrap modulo 2^BLK_W.
- R7: The filter is active when `prev_recent_pf` is 1 with the trigger, or when the used flag of entry B-1 is set. With the filter active, only B+MAX_AHEAD may be emitted, and only if the chain of R4 reaches it.
- R8: On every AGE_PERIOD-th accepted trigger, a sweep starts once that trigger's walk is done. It visits every entry one per cycle. For each entry whose used flag is set, it decrements the counter (floored at 0) and clears the flag. The sweep pauses while a trigger is presented or a walk is running.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_blk` holds its value. A full queue stalls the walk, so no candidate is lost or reordered.
- R10: `miss_ready` is 0 from the cycle after a trigger is accepted until that trigger's walk ends. A trigger is accepted only when `miss_valid` and `miss_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Shadow-cache miss trigger present |
| miss_blk | input | BLK_W | Block address B of the miss |
| prev_recent_pf | input | 1 | Block B-1 was recently prefetched (filter query result) |
| miss_ready | output | 1 | Predictor can accept a trigger |
| pf_valid | output | 1 | Prefetch candidate available |
| pf_ready | input | 1 | Consumer takes the candidate this cycle |
| pf_blk | output | BLK_W | Prefetch candidate block address |

## Verification
The assertions cover these properties on every cycle:
- setting of the used flag and of the counter on a trigger;
- exclusion of sweep writes from trigger cycles, and clearing of the used flag by the sweep;
- ascending order of back-to-back candidates;
- busy signalling after an accept;
- no queue overflow, and a stable output under back-pressure.

Three behaviours depend on a sequence of earlier triggers, so only the bench scenarios can show them: which candidates a trigger yields, where a walk stops at an unworthy block or a page edge, and how an aging pass changes later walks. The bench drives trained chains, a page edge, the filter input, an output stall and a long near-random sweep with periodic aging. It compares every emitted sequence against an arithmetic model of the two tables.

// File: rtl/fnl_pkg.sv
// Shared types for the footprint next-line prefetch predictor.
package fnl_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_t;

    // Full-strength value of the 2-bit usefulness counter
    localparam logic [1:0] WORTH_SAT = 2'd3;
endpackage

// File: rtl/fnl_table.sv
// Footprint tables: a 1-bit used flag and a 2-bit usefulness counter per
// direct-mapped entry. Assumes the trigger update and the aging sweep are
// never requested in the same cycle; the trigger update has priority.
module fnl_table #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [IDX_W-1:0] prev_idx,
    output logic             prev_touched,
    input  logic             sweep_en,
    input  logic [IDX_W-1:0] sweep_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_worth
);
    import fnl_pkg::*;

    localparam int N = 1 << IDX_W;

    logic [N-1:0] touched;
    logic [1:0]   worth [N];

    // Read ports for the filter / counter update and the walker
    always_comb begin
        prev_touched = touched[prev_idx];
        rd_worth     = worth[rd_idx];
    end

    // Table writes: trigger update first, otherwise one sweep step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                touched[i] <= 1'b0;
                worth[i]   <= 2'd0;
            end
        end else if (upd_en) begin
            touched[upd_idx] <= 1'b1;
            if (touched[prev_idx]) begin
                worth[prev_idx] <= WORTH_SAT;
            end
        end else if (sweep_en) begin
            if (touched[sweep_idx]) begin
                touched[sweep_idx] <= 1'b0;
                if (worth[sweep_idx] != 2'd0) begin
                    worth[sweep_idx] <= worth[sweep_idx] - 2'd1;
                end
            end
        end
    end

    AST_TOUCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> touched[$past(upd_idx)]);                                  // R2
    AST_WORTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && prev_touched) |=> (worth[$past(prev_idx)] == WORTH_SAT));  // R3
    AST_SWEEP_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |-> !upd_en);                                                // R8
    AST_SWEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |=> !touched[$past(sweep_idx)]);                             // R8
endmodule

// File: rtl/fnl_age_ctrl.sv
// Aging controller: counts accepted triggers and, every AGE_PERIOD of them,
// runs a sweep over all table entries one per cycle. Assumes the walker is
// idle and no trigger is presented whenever a sweep step is taken.
module fnl_age_ctrl #(
    parameter int IDX_W      = 6,
    parameter int AGE_PERIOD = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_pulse,
    input  logic             trig_pending,
    input  logic             walk_idle,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_idx
);
    localparam int CNT_W = (AGE_PERIOD > 1) ? $clog2(AGE_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AGE_PERIOD - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

    logic [CNT_W-1:0] miss_cnt;
    logic             sweep_active;

    // A sweep step only when the tables are free of trigger traffic
    always_comb begin
        sweep_en = sweep_active && walk_idle && !trig_pending;
    end

    // Trigger counter and sweep position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_cnt     <= '0;
            sweep_active <= 1'b0;
            sweep_idx    <= '0;
        end else begin
            if (miss_pulse) begin
                if (miss_cnt == CNT_LAST) begin
                    miss_cnt     <= '0;
                    sweep_active <= 1'b1;
                    sweep_idx    <= '0;
                end else begin
                    miss_cnt <= miss_cnt + CNT_W'(1);
                end
            end else if (sweep_en) begin
                sweep_idx <= sweep_idx + IDX_W'(1);
                if (sweep_idx == IDX_LAST) begin
                    sweep_active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fnl_walker.sv
// Trigger sequencer: accepts one trigger, drives the table update, then
// examines one successor per cycle and pushes worthy in-page candidates
// into the output queue. Assumes 2^IDX_W > MAX_AHEAD + 1, so the counter
// written on accept never aliases one read by the walk.
module fnl_walker #(
    parameter int BLK_W      = 16,
    parameter int IDX_W      = 6,
    parameter int PAGE_W     = 6,
    parameter int MAX_AHEAD  = 5,
    parameter int WORTHY_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    input  logic [BLK_W-1:0] trig_blk,
    input  logic             recent_in,
    output logic             trig_ready,
    input  logic             prev_touched,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic [IDX_W-1:0] prev_idx,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       rd_worth,
    input  logic             fifo_full,
    output logic             push,
    output logic [BLK_W-1:0] push_blk,
    output logic             walk_idle
);
    import fnl_pkg::*;

    localparam int STEP_W = $clog2(MAX_AHEAD + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MAX_AHEAD);
    localparam logic [1:0] WORTHY = 2'(WORTHY_MIN);

    walk_state_t       state_q;
    logic [BLK_W-1:0]  base_q;
    logic [STEP_W-1:0] step_q;
    logic              filt_q;

    logic [BLK_W-1:0]  cand;
    logic [BLK_W-1:0]  pred_blk;
    logic [BLK_W-1:0]  below_blk;
    logic              in_walk;
    logic              same_page;
    logic              worthy;
    logic              chain_ok;
    logic              want_push;
    logic              advance;
    logic              last_step;

    // Trigger side: ready when idle, table indices for the update
    always_comb begin
        in_walk    = (state_q == WALK_RUN);
        walk_idle  = !in_walk;
        trig_ready = !in_walk;
        upd_en     = trig_valid && trig_ready;
        below_blk  = trig_blk - BLK_W'(1);
        upd_idx    = trig_blk[IDX_W-1:0];
        prev_idx   = below_blk[IDX_W-1:0];
    end

    // Walk step: candidate, page check, worthiness of its predecessor
    always_comb begin
        cand      = base_q + BLK_W'(step_q);
        pred_blk  = cand - BLK_W'(1);
        rd_idx    = pred_blk[IDX_W-1:0];
        same_page = (cand[BLK_W-1:PAGE_W] == base_q[BLK_W-1:PAGE_W]);
        worthy    = (rd_worth >= WORTHY);
        chain_ok  = worthy && same_page;
        last_step = (step_q == STEP_LAST);
        want_push = in_walk && chain_ok && (!filt_q || last_step);
        push      = want_push && !fifo_full;
        push_blk  = cand;
        advance   = in_walk && (!want_push || !fifo_full);
    end

    // Sequencer state: capture trigger, step forward, stop on break or limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            base_q  <= '0;
            step_q  <= '0;
            filt_q  <= 1'b0;
        end else if (upd_en) begin
            state_q <= WALK_RUN;
            base_q  <= trig_blk;
            step_q  <= STEP_W'(1);
            filt_q  <= recent_in || prev_touched;
        end else if (advance) begin
            if (!chain_ok || last_step) begin
                state_q <= WALK_IDLE;
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_ready) |=> !trig_ready);                          // R10
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (push && $past(push)) |-> (push_blk == $past(push_blk) + BLK_W'(1))); // R4
endmodule

// File: rtl/fnl_out_fifo.sv
// Candidate queue: DEPTH entries, one push and one pop per cycle, first-word
// visible on the output. Assumes the producer never pushes when full.
module fnl_out_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop;

    // Status and head-of-queue output
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        out_valid = (count != '0);
        out_data  = mem[rd_ptr];
        pop       = out_valid && out_ready;
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            if (push && !pop) begin
                count <= count + CNT_W'(1);
            end else if (pop && !push) begin
                count <= count - CNT_W'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));                                    // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));      // R9
endmodule

// File: rtl/fnl_prefetch_predictor.sv
// Top of the footprint next-line prefetch predictor. Takes shadow-cache miss
// triggers, updates the footprint tables, walks up to MAX_AHEAD successors
// and queues worthy in-page candidates. Assumes PAGE_W < BLK_W,
// IDX_W <= BLK_W and 2^IDX_W > MAX_AHEAD + 1.
module fnl_prefetch_predictor #(
    parameter int BLK_W      = 16,
    parameter int IDX_W      = 6,
    parameter int PAGE_W     = 6,
    parameter int MAX_AHEAD  = 5,
    parameter int AGE_PERIOD = 8192,
    parameter int FIFO_DEPTH = 8,
    parameter int WORTHY_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [BLK_W-1:0] miss_blk,
    input  logic             prev_recent_pf,
    output logic             miss_ready,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [BLK_W-1:0] pf_blk
);
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic [IDX_W-1:0] prev_idx;
    logic             prev_touched;
    logic [IDX_W-1:0] rd_idx;
    logic [1:0]       rd_worth;
    logic             sweep_en;
    logic [IDX_W-1:0] sweep_idx;
    logic             fifo_full;
    logic             push;
    logic [BLK_W-1:0] push_blk;
    logic             walk_idle;

    fnl_walker #(
        .BLK_W(BLK_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W),
        .MAX_AHEAD(MAX_AHEAD), .WORTHY_MIN(WORTHY_MIN)
    ) walker_i (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(miss_valid), .trig_blk(miss_blk), .recent_in(prev_recent_pf),
        .trig_ready(miss_ready), .prev_touched(prev_touched),
        .upd_en(upd_en), .upd_idx(upd_idx), .prev_idx(prev_idx),
        .rd_idx(rd_idx), .rd_worth(rd_worth), .fifo_full(fifo_full),
        .push(push), .push_blk(push_blk), .walk_idle(walk_idle)
    );

    fnl_table #(.IDX_W(IDX_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_en), .upd_idx(upd_idx), .prev_idx(prev_idx),
        .prev_touched(prev_touched), .sweep_en(sweep_en), .sweep_idx(sweep_idx),
        .rd_idx(rd_idx), .rd_worth(rd_worth)
    );

    fnl_age_ctrl #(.IDX_W(IDX_W), .AGE_PERIOD(AGE_PERIOD)) age_i (
        .clk(clk), .rst_n(rst_n),
        .miss_pulse(upd_en), .trig_pending(miss_valid), .walk_idle(walk_idle),
        .sweep_en(sweep_en), .sweep_idx(sweep_idx)
    );

    fnl_out_fifo #(.W(BLK_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_blk), .full(fifo_full),
        .out_valid(pf_valid), .out_ready(pf_ready), .out_data(pf_blk)
    );
endmodule

// File: tb/fnl_prefetch_predictor_tb.sv
// Bench for the predictor in a small configuration: 32-entry tables,
// 16-block pages, aging every 16 triggers, 4-deep queue.
module fnl_prefetch_predictor_tb_top;
    localparam int BW  = 12;
    localparam int IW  = 5;
    localparam int PW  = 4;
    localparam int AH  = 5;
    localparam int AGE = 16;
    localparam int N   = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [BW-1:0] miss_blk = '0;
    logic          prev_recent_pf = 1'b0;
    logic          miss_ready;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [BW-1:0] pf_blk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit bp_mode = 1'b0;
    int ntrig = 0;
    int m_touch [N];
    int m_worth [N];
    int exp_q [$];
    int got_q [$];

    always #2 clk = ~clk;

    fnl_prefetch_predictor #(
        .BLK_W(BW), .IDX_W(IW), .PAGE_W(PW), .MAX_AHEAD(AH),
        .AGE_PERIOD(AGE), .FIFO_DEPTH(4), .WORTHY_MIN(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
        .prev_recent_pf(prev_recent_pf), .miss_ready(miss_ready),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_blk(pf_blk)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Consumer ready pattern, driven just after each rising edge
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            pf_ready = bp_mode ? ((cyc % 4) == 0) : 1'b1;
        end
    end

    // Output monitor: records accepted candidates and checks the hold rule (R9)
    initial begin
        bit stalled = 1'b0;
        int held = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (stalled && pf_valid) begin
                    check(pf_blk == BW'(held), "R9 hold under stall", int'(pf_blk), held);
                end
                if (pf_valid && pf_ready) got_q.push_back(int'(pf_blk));
                stalled = pf_valid && !pf_ready;
                held = int'(pf_blk);
            end
        end
    end

    // Model of one trigger: table update, then the expected candidate list
    task automatic model_trigger(input int blk, input bit recent);
        int pi = (blk - 1) & (N - 1);
        int bi = blk & (N - 1);
        bit filt = recent || (m_touch[pi] != 0);
        exp_q.delete();
        if (m_touch[pi] != 0) m_worth[pi] = 3;
        m_touch[bi] = 1;
        for (int k = 1; k <= AH; k++) begin
            int cand = (blk + k) & ((1 << BW) - 1);
            if ((cand >> PW) != (blk >> PW)) break;
            if (m_worth[(blk + k - 1) & (N - 1)] < 2) break;
            if (!filt || k == AH) exp_q.push_back(cand);
        end
    endtask

    task automatic model_age();
        for (int i = 0; i < N; i++) begin
            if (m_touch[i] != 0) begin
                if (m_worth[i] > 0) m_worth[i]--;
                m_touch[i] = 0;
            end
        end
    endtask

    // One trigger through the design, compared against the model
    task automatic run_trig(input int blk, input bit recent, input string tag);
        got_q.delete();
        model_trigger(blk, recent);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_blk = BW'(blk);
        prev_recent_pf = recent;
        @(negedge clk);
        miss_valid = 1'b0;
        prev_recent_pf = 1'b0;
        check(miss_ready == 1'b0, "R10 busy after accept", int'(miss_ready), 0);
        while (!(miss_ready && !pf_valid)) @(negedge clk);
        @(negedge clk);
        check(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check(got_q[i] == exp_q[i], {tag, " candidate"}, got_q[i], exp_q[i]);
        end
        ntrig++;
        if (ntrig % AGE == 0) begin
            repeat (3 * N) @(negedge clk);
            model_age();
        end
    endtask

    initial begin
        int s = 7;
        int blk = 'h80;
        for (int i = 0; i < N; i++) begin
            m_touch[i] = 0;
            m_worth[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_ready == 1'b1, "R1 ready after reset", int'(miss_ready), 1);
        check(pf_valid == 1'b0, "R1 no candidate after reset", int'(pf_valid), 0);
        // R1/R2/R3: fresh tables emit nothing; a pair trains the lower block
        run_trig('h200, 0, "R1 fresh");
        run_trig('h201, 0, "R3 train");
        run_trig('h200, 0, "R4 single");
        check(got_q.size() == 1, "R3 one candidate", got_q.size(), 1);
        // R4/R5: train a chain, then walk it to the limit
        for (int b = 'h300; b <= 'h306; b++) run_trig(b, 0, "R4 train");
        run_trig('h300, 0, "R4 limit");
        run_trig('h303, 0, "R5 break");
        // R6: chain crossing a page edge
        for (int b = 'h40B; b <= 'h411; b++) run_trig(b, 0, "R6 train");
        run_trig('h40C, 0, "R6 page edge");
        // R7: filter input on a trained chain
        run_trig('h300, 1, "R7 filter");
        // R9: back-pressure during a long walk
        bp_mode = 1'b1;
        run_trig('h301, 0, "R9 stall");
        run_trig('h300, 0, "R9 stall");
        bp_mode = 1'b0;
        // R8: cross several aging passes, then revisit trained chains
        for (int i = 0; i < 40; i++) run_trig('h500 + (i % 7), 0, "R8 fill");
        run_trig('h300, 0, "R8 aged");
        run_trig('h200, 0, "R8 aged");
        // Near-random sweep with sequential runs, filter and back-pressure
        for (int i = 0; i < 320; i++) begin
            s = s * 1103515245 + 12345;
            if (((s >>> 16) & 3) != 0) blk = (blk + 1) & 'hFFF;
            else blk = 'h80 + ((s >>> 8) & 'h7F);
            bp_mode = ((s >>> 20) & 7) == 0;
            run_trig(blk, ((s >>> 24) & 7) == 0, "R4 R5 R6 R7 R8 sweep");
        end
        bp_mode = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule